// File: doc/BRIEF.md
# Receiver Gain Hold-In Controller

This block is the digital decision core of a receiver automatic gain control loop. A single-cycle saturation pulse from the front amplifier asks for the low-gain setting. A peak-level sample and a squelch threshold, both unsigned words, decide when the low-gain setting may be given up again. The output is one bit: 0 selects the high-gain (35 dB) path and 1 selects the low-gain (5 dB) path.

Once low gain is engaged, a programmable hold-in timer keeps it engaged for a minimum number of cycles. This lets the gain ride through runs of zero bits, even when the peak level has already decayed. Release happens only after the timer has run out, and only while 0.8 times the peak is below the threshold. That test is done in integers as `peak*4 < threshold*5`.

A configuration input selects normal, defeated or latched operation. Any mode other than receive clears the controller. A zero threshold can never satisfy the release test, so it is reported as an invalid configuration.

Top module: `rx_gain_hold_ctrl`

## Requirements
- R1: In receive mode (`xcvr_mode`=2'b11) with `agc_cfg` normal (2'b00) or latched (2'b10), a `sat_pulse` sampled high at a clock edge sets `low_gain` to 1 after that edge.
- R2: In normal configuration, a release request is true when `peak_level*4 < squelch_thr*5`, evaluated on unsigned integers.
- R3: In normal configuration, a saturation pulse loads the hold-in timer with `hold_cycles`. With a release request present on every following cycle and no new saturation, `low_gain` stays at 1 for exactly `hold_cycles+1` clock cycles after the engaging edge.
- R4: When `agc_cfg` is defeated (2'b01 or 2'b11), `low_gain` is 0 after every edge, whatever `sat_pulse` does.
- R5: In latched configuration, `low_gain` stays at 1 after the first engage, whatever the peak and threshold are, for as long as the mode stays receive.
- R6: In sleep (2'b00), on-off transmit (2'b01) and level transmit (2'b10), `low_gain` is 0 after the next edge, the hold-in timer is cleared, and saturation pulses are ignored.
- R7: `cfg_invalid` is 1 exactly when `squelch_thr` is 0 and `agc_cfg` is normal. In that state an engaged low-gain setting is never released.
- R8: A saturation pulse that arrives while low gain is already engaged reloads the hold-in timer, so the low-gain period runs `hold_cycles+1` cycles from the last pulse.
- R9: After reset, `low_gain` is 0 and the timer is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sat_pulse | input | 1 | Front-amplifier saturation detect, one cycle per event |
| peak_level | input | PEAK_W | Unsigned peak-detector sample |
| squelch_thr | input | THR_W | Unsigned squelch threshold |
| xcvr_mode | input | 2 | 00 sleep, 01 on-off transmit, 10 level transmit, 11 receive |
| agc_cfg | input | 2 | 00 normal, 01 or 11 defeated, 10 latched |
| hold_cycles | input | HOLD_W | Hold-in time in clock cycles |
| low_gain | output | 1 | 1 selects low gain, 0 selects high gain |
| cfg_invalid | output | 1 | Zero threshold in normal configuration |

## Verification
The release comparison is swept over every pair of peak and threshold values of a 4-bit build. This separates the 0.8 scaling from a plain compare and exposes the zero-threshold case. The hold-in length is measured for every timer value from 0 to 15, which catches off-by-one loads and decrements. A second saturation pulse in the middle of a hold period shows whether the timer reloads. Per-configuration and per-mode runs show that the defeated, latched and non-receive paths override the normal release logic.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [1:0] {
    XM_SLEEP    = 2'b00,
    XM_TX_ONOFF = 2'b01,
    XM_TX_LEVEL = 2'b10,
    XM_RX       = 2'b11
  } xcvr_mode_e;

  typedef enum logic [1:0] {
    GC_NORMAL  = 2'b00,
    GC_DEFEAT  = 2'b01,
    GC_LATCH   = 2'b10,
    GC_DEFEAT2 = 2'b11
  } gain_cfg_e;

  function automatic logic cfg_defeated(input logic [1:0] c);
    return c[0];
  endfunction

  function automatic logic cfg_latched(input logic [1:0] c);
    return c == GC_LATCH;
  endfunction

  function automatic logic cfg_normal(input logic [1:0] c);
    return c == GC_NORMAL;
  endfunction
endpackage

// File: rtl/agc_release_cmp.sv
module agc_release_cmp #(
  parameter int PEAK_W = 8,
  parameter int THR_W  = 8
) (
  input  logic [PEAK_W-1:0] peak_level,
  input  logic [THR_W-1:0]  squelch_thr,
  output logic              release_req,
  output logic              thr_zero
);
  localparam int MAXW = (PEAK_W > THR_W) ? PEAK_W : THR_W;
  localparam int CW   = MAXW + 3;

  function automatic logic scaled_below(input logic [PEAK_W-1:0] p,
                                        input logic [THR_W-1:0]  t);
    logic [CW-1:0] p4;
    logic [CW-1:0] t5;
    p4 = CW'(p) << 2;
    t5 = (CW'(t) << 2) + CW'(t);
    return p4 < t5;
  endfunction

  assign release_req = scaled_below(peak_level, squelch_thr);
  assign thr_zero    = (squelch_thr == '0);
endmodule

// File: rtl/agc_hold_timer.sv
module agc_hold_timer #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [HOLD_W-1:0] load_val,
  input  logic              run,
  output logic              done
);
  logic [HOLD_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (clear)               cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/agc_gain_fsm.sv
module agc_gain_fsm
  import agc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_rx,
  input  logic [1:0] cfg,
  input  logic       sat,
  input  logic       release_req,
  input  logic       hold_done,
  output logic       low_gain,
  output logic       timer_clear,
  output logic       timer_load,
  output logic       timer_run
);
  logic engaged_q, engaged_d;
  logic clear_all, is_norm, is_latch;

  always_comb begin
    clear_all   = !in_rx || cfg_defeated(cfg);
    is_norm     = in_rx && cfg_normal(cfg);
    is_latch    = in_rx && cfg_latched(cfg);
    timer_clear = clear_all || is_latch;
    timer_load  = is_norm && sat;
    timer_run   = is_norm && engaged_q && !sat;
    if (clear_all)     engaged_d = 1'b0;
    else if (is_latch) engaged_d = engaged_q || sat;
    else if (sat)      engaged_d = 1'b1;
    else               engaged_d = engaged_q && !(hold_done && release_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) engaged_q <= 1'b0;
    else        engaged_q <= engaged_d;
  end

  assign low_gain = engaged_q;
endmodule

// File: rtl/rx_gain_hold_ctrl.sv
module rx_gain_hold_ctrl
  import agc_pkg::*;
#(
  parameter int PEAK_W = 8,
  parameter int THR_W  = 8,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sat_pulse,
  input  logic [PEAK_W-1:0] peak_level,
  input  logic [THR_W-1:0]  squelch_thr,
  input  logic [1:0]        xcvr_mode,
  input  logic [1:0]        agc_cfg,
  input  logic [HOLD_W-1:0] hold_cycles,
  output logic              low_gain,
  output logic              cfg_invalid
);
  logic release_req, thr_zero, hold_done;
  logic t_clear, t_load, t_run, in_rx;

  assign in_rx = (xcvr_mode == XM_RX);

  agc_release_cmp #(.PEAK_W(PEAK_W), .THR_W(THR_W)) u_cmp (
    .peak_level (peak_level),
    .squelch_thr(squelch_thr),
    .release_req(release_req),
    .thr_zero   (thr_zero)
  );

  agc_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (t_clear),
    .load    (t_load),
    .load_val(hold_cycles),
    .run     (t_run),
    .done    (hold_done)
  );

  agc_gain_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_rx      (in_rx),
    .cfg        (agc_cfg),
    .sat        (sat_pulse),
    .release_req(release_req),
    .hold_done  (hold_done),
    .low_gain   (low_gain),
    .timer_clear(t_clear),
    .timer_load (t_load),
    .timer_run  (t_run)
  );

  assign cfg_invalid = thr_zero && cfg_normal(agc_cfg);
endmodule

// File: rtl/rx_gain_hold_ctrl_chk.sv
module rx_gain_hold_ctrl_chk #(
  parameter int HOLD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sat_pulse,
  input logic [1:0]        xcvr_mode,
  input logic [1:0]        agc_cfg,
  input logic [HOLD_W-1:0] hold_cycles,
  input logic              low_gain,
  input logic              cfg_invalid,
  input logic              release_req,
  input logic              hold_done
);
  logic rx, norm;
  assign rx   = (xcvr_mode == 2'b11);
  assign norm = rx && (agc_cfg == 2'b00);

  assert_engage_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx && !agc_cfg[0] && sat_pulse) |=> low_gain);

  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (norm && low_gain && hold_done && release_req && !sat_pulse) |=> !low_gain);

  assert_hold_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (norm && low_gain && !hold_done) |=> low_gain);

  assert_defeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx && agc_cfg[0]) |=> !low_gain);

  assert_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx && agc_cfg == 2'b10 && low_gain) |=> low_gain);

  assert_nonrx_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx |=> (!low_gain && hold_done));

  assert_zero_thr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (norm && cfg_invalid && low_gain && !sat_pulse) |=> low_gain);

  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (norm && sat_pulse && hold_cycles != '0) |=> !hold_done);
endmodule

bind rx_gain_hold_ctrl rx_gain_hold_ctrl_chk #(.HOLD_W(HOLD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sat_pulse  (sat_pulse),
  .xcvr_mode  (xcvr_mode),
  .agc_cfg    (agc_cfg),
  .hold_cycles(hold_cycles),
  .low_gain   (low_gain),
  .cfg_invalid(cfg_invalid),
  .release_req(release_req),
  .hold_done  (hold_done)
);

// File: tb/rx_gain_hold_ctrl_tb.sv
module rx_gain_hold_ctrl_tb;
  localparam int PW = 4, TW = 4, HW = 4;

  logic clk = 0, rst_n = 0, sat = 0;
  logic [PW-1:0] peak = 0;
  logic [TW-1:0] thr = 0;
  logic [1:0] mode = 2'b11, cfg = 2'b00;
  logic [HW-1:0] hold = 0;
  logic low_gain, cfg_invalid;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rx_gain_hold_ctrl #(.PEAK_W(PW), .THR_W(TW), .HOLD_W(HW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sat_pulse(sat), .peak_level(peak),
    .squelch_thr(thr), .xcvr_mode(mode), .agc_cfg(cfg), .hold_cycles(hold),
    .low_gain(low_gain), .cfg_invalid(cfg_invalid));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic clear_state();
    mode = 2'b00; sat = 0; tick(); mode = 2'b11;
  endtask

  // engage in normal RX with given hold, release held true afterwards, return low duration
  task automatic measure_hold(input int h, output int dur);
    cfg = 2'b00; hold = HW'(h); peak = 0; thr = 8; sat = 1; tick(); sat = 0;
    dur = 0;
    while (low_gain && dur < 40) begin dur++; tick(); end
  endtask

  initial begin
    int d;
    tick(); tick();
    check("R9 reset low_gain", low_gain, 0);
    rst_n = 1; tick();
    check("R9 after reset", low_gain, 0);

    // R2 / R7 exhaustive compare sweep
    for (int t = 0; t < 16; t++) begin
      for (int p = 0; p < 16; p++) begin
        clear_state();
        cfg = 2'b00; hold = 0; peak = 15; thr = 1; sat = 1; tick();
        sat = 0; peak = PW'(p); thr = TW'(t);
        #1 check("R7 cfg_invalid", cfg_invalid, (t == 0) ? 1 : 0);
        tick();
        check("R2 release compare", low_gain, (p*4 < t*5) ? 0 : 1);
      end
    end

    // R3 hold length sweep
    for (int h = 0; h < 16; h++) begin
      clear_state();
      measure_hold(h, d);
      check("R3 hold length", d, h + 1);
    end

    // R8 reload: second pulse 3 cycles in
    clear_state();
    cfg = 2'b00; hold = 5; peak = 0; thr = 8; sat = 1; tick(); sat = 0;
    tick(); tick(); tick();
    sat = 1; tick(); sat = 0;
    d = 0;
    while (low_gain && d < 40) begin d++; tick(); end
    check("R8 reload length", d, 6);

    // R7 zero threshold: never released
    clear_state();
    cfg = 2'b00; hold = 0; peak = 0; thr = 0; sat = 1; tick(); sat = 0;
    for (int i = 0; i < 10; i++) tick();
    check("R7 zero thr holds", low_gain, 1);

    // R4 defeated
    for (int c = 1; c < 4; c += 2) begin
      clear_state();
      cfg = 2'(c); peak = 15; thr = 1; sat = 1; tick();
      check("R4 defeated sat", low_gain, 0);
      sat = 0; tick();
      check("R4 defeated idle", low_gain, 0);
    end

    // R5 latched, then R6 leave RX
    clear_state();
    cfg = 2'b10; hold = 0; sat = 1; peak = 0; thr = 15; tick(); sat = 0;
    check("R1 latched engage", low_gain, 1);
    for (int i = 0; i < 20; i++) tick();
    check("R5 latched holds", low_gain, 1);
    mode = 2'b10; tick();
    check("R6 latched cleared by tx", low_gain, 0);

    // R6 each non-RX mode clears and ignores sat
    for (int m = 0; m < 3; m++) begin
      clear_state();
      cfg = 2'b00; hold = 15; peak = 15; thr = 1; sat = 1; tick(); sat = 0;
      check("R1 normal engage", low_gain, 1);
      mode = 2'(m); tick();
      check("R6 mode clears", low_gain, 0);
      sat = 1; tick(); sat = 0;
      check("R6 sat ignored", low_gain, 0);
      mode = 2'b11; hold = 0; peak = 0; thr = 8; sat = 1; tick(); sat = 0; tick();
      check("R6 timer cleared", low_gain, 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule